// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block arbitrates twelve interrupt request lines for a small 8-bit microcontroller core. Eleven ordinary sources are each placed on a low or a high priority tier by a per-source bit. One power-supply-monitor source always sits alone on a third tier above both. Software configures the block through a byte-wide register port. The block samples the request lines and picks a winner: first the highest tier that has an eligible request, then the first source in a fixed polling order within that tier.

The controller keeps a three-bit in-service mask with one bit per tier. It raises a vector request to the core only when the winner's tier is strictly above every tier that is currently in service. A routine therefore cannot be interrupted by a request of its own tier or a lower one, while a higher tier nests on top of it. The core acknowledges a vector, which marks the winner's tier as in service, and pulses return-from-interrupt at the end of each routine, which releases the highest tier in service. The block only acts while the core is running. Waking the core from its shutdown mode is handled elsewhere.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four configuration registers read 0x00, `in_service_o` is 3'b000 and `vec_req_o` is 0.
- R2: Register address 0 is the main enable register. Bit 7 is the global enable. Bits 6..0 enable sources 7..1 in that order: bit 6 is the temperature ADC (source 7), bit 5 Timer 2 (6), bit 4 the UART (5), bit 3 Timer 1 (4), bit 2 external 1 (3), bit 1 Timer 0 (2) and bit 0 external 0 (1). All 8 bits read back as written.
- R3: Sources 1..11 can win only when the global enable is set. Source 0, the power monitor, depends only on its own enable, which is bit 0 of address 3, and ignores the global enable.
- R4: A request is considered only after it has been sampled at a clock edge. `vec_req_o` stays 0 until the first rising edge at which `req_i` is high.
- R5: At address 1, bit k-1 set puts source k (k = 1..7) on the high tier, and bit 7 reads 0. At address 2, bits 3..0 enable sources 11..8 (bit n enables source 8+n) and bits 7..4 put sources 11..8 on the high tier (bit 4+n for source 8+n).
- R6: When eligible requests exist on several tiers, the winner comes from the highest tier. The tiers from top to bottom are power monitor, high, low.
- R7: Within one tier the lowest source index wins. This is the fixed polling order 0, 1, 2, …, 11.
- R8: `vec_ack_i` high while `vec_req_o` is high sets, at that edge, the `in_service_o` bit of the winner's tier (bit 0 low, bit 1 high, bit 2 power monitor).
- R9: While a tier is in service, no request from that tier or a lower tier raises `vec_req_o`.
- R10: A high-tier request raises `vec_req_o` while only the low tier is in service. A power-monitor request raises it while the high tier is in service.
- R11: A `reti_i` pulse clears the highest set bit of `in_service_o`, and has no effect when no bit is set. When acknowledge and return fall in the same cycle, both take effect at that edge.
- R12: `vec_id_o` gives the winning source index 0..11 whenever `vec_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 12 | Request lines, bit n = source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| vec_req_o | output | 1 | Vector request to the core |
| vec_id_o | output | 4 | Winning source index |
| vec_ack_i | input | 1 | Core accepts the offered vector |
| reti_i | input | 1 | Return-from-interrupt pulse |
| in_service_o | output | 3 | Tiers currently in service |

## Verification
The core's acknowledge of a new vector and its return from the routine already running can land on the same clock edge. In that case one in-service bit must be set and another cleared together. The bench provokes this by putting the low tier in service and raising a high-tier request. It then holds `vec_ack_i` and `reti_i` high for the same single cycle. The result is judged by expecting `in_service_o` to go from 3'b001 to 3'b010, with no intermediate state and no lost update.

// File: rtl/irq_nest_pkg.sv
// Shared constants and types for the nested interrupt controller.
// Assumes exactly one power-monitor source at index 0.
package irq_nest_pkg;
    localparam int NSRC   = 12;
    localparam int NLVL   = 3;
    localparam int IDW    = $clog2(NSRC);
    localparam int LVLW   = $clog2(NLVL);
    localparam int NMAIN  = 8;
    localparam int NSEC   = NSRC - NMAIN;

    typedef logic [LVLW-1:0] lvl_t;

    localparam lvl_t LVL_LOW  = lvl_t'(0);
    localparam lvl_t LVL_HIGH = lvl_t'(1);
    localparam lvl_t LVL_PWR  = lvl_t'(2);

    localparam logic [1:0] ADR_ENA = 2'd0;
    localparam logic [1:0] ADR_PRI = 2'd1;
    localparam logic [1:0] ADR_SEC = 2'd2;
    localparam logic [1:0] ADR_PWR = 2'd3;
endpackage

// File: rtl/irq_nest_regs.sv
// Configuration register file: main enable, priority, secondary
// enable/priority and power-monitor enable. It assumes 8 main sources and
// at most four secondary ones. The read data is combinational.
module irq_nest_regs
    import irq_nest_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [1:0]      addr_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    output logic [NSRC-1:0] src_en_o,
    output logic [NSRC-1:0] src_hi_o,
    output logic            glob_en_o
);
    logic [7:0]       ena_q;
    logic [NMAIN-2:0] pri_q;
    logic [NSEC-1:0]  sec_en_q;
    logic [NSEC-1:0]  sec_hi_q;
    logic             pwr_en_q;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q    <= '0;
            pri_q    <= '0;
            sec_en_q <= '0;
            sec_hi_q <= '0;
            pwr_en_q <= 1'b0;
        end else if (wr_i) begin
            case (addr_i)
                ADR_ENA: ena_q <= wdata_i;
                ADR_PRI: pri_q <= wdata_i[NMAIN-2:0];
                ADR_SEC: begin
                    sec_en_q <= wdata_i[NSEC-1:0];
                    sec_hi_q <= wdata_i[4 +: NSEC];
                end
                default: pwr_en_q <= wdata_i[0];
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_ENA: rdata_o = ena_q;
            ADR_PRI: rdata_o[NMAIN-2:0] = pri_q;
            ADR_SEC: begin
                rdata_o[NSEC-1:0]  = sec_en_q;
                rdata_o[4 +: NSEC] = sec_hi_q;
            end
            default: rdata_o[0] = pwr_en_q;
        endcase
    end

    // Map register fields onto per-source enable and tier bits.
    always_comb begin
        src_en_o              = '0;
        src_hi_o              = '0;
        src_en_o[0]           = pwr_en_q;
        src_en_o[NMAIN-1:1]   = ena_q[NMAIN-2:0];
        src_en_o[NSRC-1:NMAIN] = sec_en_q;
        src_hi_o[NMAIN-1:1]   = pri_q;
        src_hi_o[NSRC-1:NMAIN] = sec_hi_q;
    end

    assign glob_en_o = ena_q[7];

    // R2: a write to the main enable register is held exactly.
    a_r2_ena_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_ENA) |=> (ena_q == $past(wdata_i)));
endmodule

// File: rtl/irq_nest_arb.sv
// Request sampler and tier/polling arbiter. A request is registered once
// before it can win. The winner comes from the highest tier that has an
// eligible request, and then has the lowest index in that tier. Source 0
// is the power monitor and is not gated by the global enable.
module irq_nest_arb
    import irq_nest_pkg::*;
#(
    parameter int N_SRC = NSRC,
    localparam int W_ID = $clog2(N_SRC)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic [N_SRC-1:0] src_hi_i,
    input  logic             glob_en_i,
    output logic             win_vld_o,
    output logic [W_ID-1:0]  win_id_o,
    output lvl_t             win_lvl_o
);
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] elig;
    lvl_t             src_lvl [N_SRC];

    // Sample the raw request lines once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Per-source eligibility and tier assignment.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g == 0) begin : g_pwr
            assign elig[g]    = req_q[g] & src_en_i[g];
            assign src_lvl[g] = LVL_PWR;
        end else begin : g_std
            assign elig[g]    = req_q[g] & src_en_i[g] & glob_en_i;
            assign src_lvl[g] = src_hi_i[g] ? LVL_HIGH : LVL_LOW;
        end
    end

    // Pick the top tier first, then the lowest index within it.
    always_comb begin
        win_vld_o = 1'b0;
        win_id_o  = '0;
        win_lvl_o = LVL_LOW;
        for (int l = NLVL - 1; l >= 0; l--) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (!win_vld_o && elig[i] && src_lvl[i] == lvl_t'(l)) begin
                    win_vld_o = 1'b1;
                    win_id_o  = W_ID'(i);
                    win_lvl_o = lvl_t'(l);
                end
            end
        end
    end

    // R7: the chosen source really is an eligible one.
    a_r7_win_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> elig[win_id_o]);
    // R6: a power-monitor request cannot lose to a lower tier.
    a_r6_pwr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        elig[0] |-> (win_vld_o && win_id_o == '0));
    // R4: nothing wins without a sampled request.
    a_r4_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |-> !win_vld_o);
endmodule

// File: rtl/irq_nest_svc.sv
// In-service tracker: one bit per tier. An acknowledge sets the bit of the
// accepted tier. A return clears the highest set bit. Both may occur in
// one cycle. It also reports whether a candidate tier may preempt.
module irq_nest_svc
    import irq_nest_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_i,
    input  lvl_t            ack_lvl_i,
    input  logic            reti_i,
    input  lvl_t            cand_lvl_i,
    output logic            may_enter_o,
    output logic [NLVL-1:0] mask_o
);
    logic [NLVL-1:0] mask_q;
    logic [NLVL-1:0] top_bit;
    logic [NLVL-1:0] mask_d;

    // Isolate the highest set tier bit.
    always_comb begin
        top_bit = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (mask_q[l]) top_bit = NLVL'(1) << l;
        end
    end

    // Combine return and acknowledge into the next mask.
    always_comb begin
        mask_d = mask_q;
        if (reti_i) mask_d = mask_d & ~top_bit;
        if (ack_i)  mask_d = mask_d | (NLVL'(1) << ack_lvl_i);
    end

    // Hold the in-service mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign may_enter_o = ((mask_q >> cand_lvl_i) == '0);
    assign mask_o      = mask_q;

    // R8: an acknowledge leaves its tier in service.
    a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> mask_q[$past(ack_lvl_i)]);
    // R11: a lone return removes exactly one tier when one is active.
    a_r11_reti_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && mask_q != '0) |=>
        ($countones(mask_q) == $countones($past(mask_q)) - 1));
    // R11: a return with nothing in service changes nothing.
    a_r11_reti_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && mask_q == '0) |=> (mask_q == '0));
endmodule

// File: rtl/irq_nest_ctrl.sv
// Top of the three-tier nested interrupt controller. It joins the register
// file, the arbiter and the in-service tracker, and it offers a vector only
// when the winner's tier lies above every tier in service. It assumes the
// core holds vec_ack_i for one cycle per accepted vector.
module irq_nest_ctrl
    import irq_nest_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_addr_i,
    input  logic [7:0]      reg_wdata_i,
    output logic [7:0]      reg_rdata_o,
    output logic            vec_req_o,
    output logic [IDW-1:0]  vec_id_o,
    input  logic            vec_ack_i,
    input  logic            reti_i,
    output logic [NLVL-1:0] in_service_o
);
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src_hi;
    logic            glob_en;
    logic            win_vld;
    logic [IDW-1:0]  win_id;
    lvl_t            win_lvl;
    logic            may_enter;
    logic            ack_ok;

    irq_nest_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .src_en_o  (src_en),
        .src_hi_o  (src_hi),
        .glob_en_o (glob_en)
    );

    irq_nest_arb #(.N_SRC(NSRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .src_en_i  (src_en),
        .src_hi_i  (src_hi),
        .glob_en_i (glob_en),
        .win_vld_o (win_vld),
        .win_id_o  (win_id),
        .win_lvl_o (win_lvl)
    );

    // Only an acknowledge of an offered vector counts.
    assign ack_ok = vec_ack_i & vec_req_o;

    irq_nest_svc u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_ok),
        .ack_lvl_i   (win_lvl),
        .reti_i      (reti_i),
        .cand_lvl_i  (win_lvl),
        .may_enter_o (may_enter),
        .mask_o      (in_service_o)
    );

    assign vec_req_o = win_vld & may_enter;
    assign vec_id_o  = win_id;

    // R9: an offered vector never sits at or below an active tier.
    a_r9_no_same_tier: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> ((in_service_o >> win_lvl) == '0));
    // R10: a power-monitor winner is always offered unless its tier is active.
    a_r10_pwr_preempts: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && win_lvl == LVL_PWR && !in_service_o[2]) |-> vec_req_o);
endmodule

// File: tb/irq_nest_ctrl_tb.sv
// Self-checking bench: a table of single-arbitration vectors, then directed
// reset, sampling, read-back and nesting tests.
module irq_nest_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] req = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        vreq;
    logic [3:0]  vid;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic [2:0]  ins;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_nest_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .vec_req_o(vreq), .vec_id_o(vid), .vec_ack_i(ack),
        .reti_i(reti), .in_service_o(ins)
    );

    typedef struct packed {
        logic [11:0] rq;
        logic [7:0]  ena;
        logic [7:0]  pri;
        logic [7:0]  sec;
        logic        pwr;
        logic        ev;
        logic [3:0]  eid;
        logic [3:0]  tag;
    } vec_t;

    // Rows: requests, enable, priority, secondary, power enable, expected.
    localparam vec_t TBL [12] = '{
        '{12'h004, 8'h82, 8'h00, 8'h00, 1'b0, 1'b1, 4'd2,  4'd2},  // R2
        '{12'h004, 8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0,  4'd3},  // R3
        '{12'h001, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 4'd0,  4'd3},  // R3
        '{12'h022, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 4'd1,  4'd7},  // R7
        '{12'h022, 8'hFF, 8'h10, 8'h00, 1'b0, 1'b1, 4'd5,  4'd6},  // R6
        '{12'h088, 8'hFF, 8'h7F, 8'h00, 1'b0, 1'b1, 4'd3,  4'd7},  // R7
        '{12'h900, 8'h80, 8'h00, 8'h0F, 1'b0, 1'b1, 4'd8,  4'd5},  // R5
        '{12'h900, 8'h80, 8'h00, 8'h8F, 1'b0, 1'b1, 4'd11, 4'd5},  // R5
        '{12'hFFF, 8'hFF, 8'h7F, 8'h0F, 1'b1, 1'b1, 4'd0,  4'd6},  // R6
        '{12'hFFF, 8'hFF, 8'h00, 8'h0F, 1'b0, 1'b1, 4'd1,  4'd12}, // R12
        '{12'h040, 8'hC0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0,  4'd2},  // R2
        '{12'h500, 8'h80, 8'h00, 8'h02, 1'b0, 1'b0, 4'd0,  4'd5}   // R5
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, input logic [7:0] exp, input string what);
        addr = a;
        #1;
        chk(rdata == exp, what, int'(rdata), int'(exp));
    endtask

    task automatic cfg(input logic [7:0] e, input logic [7:0] p,
                       input logic [7:0] s, input logic pw);
        wreg(2'd0, e); wreg(2'd1, p); wreg(2'd2, s); wreg(2'd3, {7'b0, pw});
    endtask

    task automatic chk_vec(input logic ev, input logic [3:0] eid, input string what);
        chk(vreq == ev, {what, " vec_req"}, int'(vreq), int'(ev));
        if (ev) chk(vid == eid, {what, " vec_id"}, int'(vid), int'(eid));
    endtask

    task automatic do_ack(input logic with_reti);
        ack = 1'b1; reti = with_reti;
        step();
        ack = 1'b0; reti = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rreg(2'd0, 8'h00, "R1 enable reset");
        rreg(2'd1, 8'h00, "R1 priority reset");
        rreg(2'd2, 8'h00, "R1 secondary reset");
        rreg(2'd3, 8'h00, "R1 power enable reset");
        chk(ins == 3'b000, "R1 in_service reset", int'(ins), 0);
        chk(vreq == 1'b0, "R1 vec_req reset", int'(vreq), 0);

        // R2 / R5: read-back layout.
        wreg(2'd0, 8'hA5); rreg(2'd0, 8'hA5, "R2 enable readback");
        wreg(2'd1, 8'hFF); rreg(2'd1, 8'h7F, "R5 priority bit7 reads 0");
        wreg(2'd2, 8'h5A); rreg(2'd2, 8'h5A, "R5 secondary readback");

        // R4: no request before the sampling edge.
        cfg(8'h82, 8'h00, 8'h00, 1'b0);
        req[2] = 1'b1;
        #1;
        chk(vreq == 1'b0, "R4 before sample edge", int'(vreq), 0);
        @(negedge clk);
        chk_vec(1'b1, 4'd2, "R4 after sample edge");
        req = '0;
        step();

        // Table walk.
        for (int i = 0; i < 12; i++) begin
            cfg(TBL[i].ena, TBL[i].pri, TBL[i].sec, TBL[i].pwr);
            req = TBL[i].rq;
            step();
            n_run++;
            if (vreq != TBL[i].ev || (TBL[i].ev && vid != TBL[i].eid)) begin
                n_fail++;
                $display("FAIL R%0d table row %0d actual=%0b/%0d expected=%0b/%0d",
                         TBL[i].tag, i, vreq, vid, TBL[i].ev, TBL[i].eid);
            end
            req = '0;
            step();
        end

        // Nesting: source 1 high, others low, power monitor enabled.
        cfg(8'hFF, 8'h01, 8'h00, 1'b1);
        req[2] = 1'b1; step();
        chk_vec(1'b1, 4'd2, "R12 low request offered");
        do_ack(1'b0); req[2] = 1'b0;
        chk(ins == 3'b001, "R8 low acknowledged", int'(ins), 1);

        req[3] = 1'b1; step(); step();
        chk_vec(1'b0, 4'd0, "R9 low blocked by low");

        req[1] = 1'b1; step();
        chk_vec(1'b1, 4'd1, "R10 high preempts low");
        do_ack(1'b0); req[1] = 1'b0;
        chk(ins == 3'b011, "R8 high acknowledged", int'(ins), 3);
        step();
        chk_vec(1'b0, 4'd0, "R9 low blocked by high");

        req[0] = 1'b1; step();
        chk_vec(1'b1, 4'd0, "R10 power preempts high");
        do_ack(1'b0); req[0] = 1'b0;
        chk(ins == 3'b111, "R8 power acknowledged", int'(ins), 7);

        do_reti();
        chk(ins == 3'b011, "R11 return clears top", int'(ins), 3);
        do_reti();
        chk(ins == 3'b001, "R11 return clears high", int'(ins), 1);
        chk_vec(1'b0, 4'd0, "R9 pending low still blocked");
        do_reti();
        chk(ins == 3'b000, "R11 return clears low", int'(ins), 0);
        chk_vec(1'b1, 4'd3, "R12 pending low offered");
        do_ack(1'b0); req[3] = 1'b0;
        chk(ins == 3'b001, "R8 second low acknowledged", int'(ins), 1);

        // R11: acknowledge and return in the same cycle.
        req[1] = 1'b1; step();
        chk_vec(1'b1, 4'd1, "R10 high over low again");
        do_ack(1'b1); req[1] = 1'b0;
        chk(ins == 3'b010, "R11 ack with reti same cycle", int'(ins), 2);
        do_reti();
        chk(ins == 3'b000, "R11 final return", int'(ins), 0);
        do_reti();
        chk(ins == 3'b000, "R11 return when idle", int'(ins), 0);

        report();
    end
endmodule